// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block sits beside a DDR SDRAM device and samples its command pins once per clock. It turns chip select, RAS, CAS and WE into a named command code. It follows the device through three states: idle, auto-refresh in progress, and mode register write in progress. In every cycle it reports whether the command just sampled is allowed in the state the device is in.

Two recovery times are parameters counted in clock cycles: the refresh cycle time `T_RFC` and the register-set cycle time `T_MRD`. While either one runs, the device accepts only deselect and no-operation. Any other command raises a one-cycle illegal pulse. A sample is judged only when the clock enable was high in both the previous cycle and the current one.

An input from the surrounding bank tracker says whether every bank is idle. An auto-refresh or mode register set issued while that input is low counts as a violation.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While `cs_ni` is high, the decoded command is deselect (code 0), whatever `ras_ni`, `cas_ni`, `we_ni` and `a10_i` hold.
- R2: With `cs_ni` low, `{ras_ni,cas_ni,we_ni}` decodes as follows. 111 is no-operation (1). 110 is burst terminate (2). 101 is read (3). 100 is write (4). 011 is activate (5). 010 is precharge (6), or precharge-all (7) when `a10_i` is high. 001 is auto-refresh (8). 000 is mode register set (9).
- R3: While `rst_ni` is low, `state_o` is idle (0), `illegal_o` is low and `cmd_o` is deselect (0).
- R4: In the refreshing state (`state_o` = 1), deselect and no-operation are legal. Every other command sets `illegal_o`.
- R5: An accepted auto-refresh puts `state_o` at 1 from the next cycle, for exactly `T_RFC` cycles, and then returns it to idle.
- R6: In the mode-setting state (`state_o` = 2), deselect and no-operation are legal. Every other command sets `illegal_o`.
- R7: An accepted mode register set puts `state_o` at 2 from the next cycle, for exactly `T_MRD` cycles, and then returns it to idle.
- R8: When `cke_i` is low in the current cycle or was low in the previous one, the sample is skipped. It raises no flag and starts no state change. The recovery timers keep running.
- R9: In idle, an auto-refresh or mode register set sampled while `banks_idle_i` is low sets `illegal_o`, and the state stays idle.
- R10: `cmd_o` and `illegal_o` are registered and appear one cycle after the command is sampled. `illegal_o` is high only for cycles that follow an offending sample.
- R11: In idle, every other command is legal and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin of the device |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| a10_i | input | 1 | Address bit 10, selects all banks on precharge |
| banks_idle_i | input | 1 | High when every bank is idle |
| cmd_o | output | 4 | Decoded command code of the last sample |
| state_o | output | 2 | Monitor state: 0 idle, 1 refreshing, 2 mode setting |
| illegal_o | output | 1 | Pulse: last sample was illegal |

## Verification
Every result is registered once. The decoded code, the illegal pulse and a state entry all appear one cycle after the edge that samples the command. A state exit shows up on the edge `T_RFC` or `T_MRD` cycles after that entry. The bench drives the pins on the falling edge. Its behavioural model updates on the rising edge from the same inputs. All three outputs are compared against the model on the following falling edge, so each comparison sees the result of exactly one sampled command.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_PREA  = 4'd7,
    CMD_REF   = 4'd8,
    CMD_MRS   = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REFRESH = 2'd1,
    ST_MODESET = 2'd2
  } mon_state_e;

  function automatic logic cmd_is_quiet(cmd_e c);
    return (c == CMD_DESEL) || (c == CMD_NOP);
  endfunction
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  input  logic a10_i,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) begin
      cmd_o = CMD_DESEL;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b110:  cmd_o = CMD_BST;
        3'b101:  cmd_o = CMD_READ;
        3'b100:  cmd_o = CMD_WRITE;
        3'b011:  cmd_o = CMD_ACT;
        3'b010:  cmd_o = a10_i ? CMD_PREA : CMD_PRE;
        3'b001:  cmd_o = CMD_REF;
        default: cmd_o = CMD_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdram_recovery_timer.sv
module sdram_recovery_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_state_tracker.sv
module sdram_state_tracker
  import sdram_mon_pkg::*;
#(
  parameter int               CNT_W    = 4,
  parameter logic [CNT_W-1:0] RFC_LOAD = '0,
  parameter logic [CNT_W-1:0] MRD_LOAD = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chk_en_i,
  input  cmd_e             cmd_i,
  input  logic             banks_idle_i,
  input  logic             timer_zero_i,
  output mon_state_e       state_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             illegal_o
);
  mon_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = RFC_LOAD;
    illegal_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (chk_en_i && (cmd_i == CMD_REF || cmd_i == CMD_MRS)) begin
          if (!banks_idle_i) begin
            illegal_o = 1'b1;
          end else begin
            load_o     = 1'b1;
            state_d    = (cmd_i == CMD_REF) ? ST_REFRESH : ST_MODESET;
            load_val_o = (cmd_i == CMD_REF) ? RFC_LOAD : MRD_LOAD;
          end
        end
      end
      default: begin
        illegal_o = chk_en_i && !cmd_is_quiet(cmd_i);
        if (timer_zero_i) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int T_RFC = 10,
  parameter int T_MRD = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cke_i,
  input  logic       cs_ni,
  input  logic       ras_ni,
  input  logic       cas_ni,
  input  logic       we_ni,
  input  logic       a10_i,
  input  logic       banks_idle_i,
  output logic [3:0] cmd_o,
  output logic [1:0] state_o,
  output logic       illegal_o
);
  localparam int MAX_T = (T_RFC > T_MRD) ? T_RFC : T_MRD;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] RFC_LOAD = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD - 1);

  cmd_e             cmd_d, cmd_q;
  mon_state_e       state;
  logic             cke_q, chk_en, illegal_d, illegal_q;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  assign chk_en = cke_i & cke_q;

  sdram_cmd_decode u_dec (
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .a10_i (a10_i),
    .cmd_o (cmd_d)
  );

  sdram_state_tracker #(
    .CNT_W   (CNT_W),
    .RFC_LOAD(RFC_LOAD),
    .MRD_LOAD(MRD_LOAD)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .chk_en_i    (chk_en),
    .cmd_i       (cmd_d),
    .banks_idle_i(banks_idle_i),
    .timer_zero_i(tmr_zero),
    .state_o     (state),
    .load_o      (tmr_load),
    .load_val_o  (tmr_val),
    .illegal_o   (illegal_d)
  );

  sdram_recovery_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q     <= 1'b0;
      cmd_q     <= CMD_DESEL;
      illegal_q <= 1'b0;
    end else begin
      cke_q     <= cke_i;
      cmd_q     <= cmd_d;
      illegal_q <= illegal_d;
    end
  end

  assign cmd_o     = cmd_q;
  assign state_o   = state;
  assign illegal_o = illegal_q;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int T_RFC = 10,
  parameter int T_MRD = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cke_i,
  input logic       cs_ni,
  input logic [3:0] cmd_o,
  input logic [1:0] state_o,
  input logic       illegal_o
);
  logic [31:0] dwell_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             dwell_q <= '0;
    else if (state_o != 2'd0) dwell_q <= dwell_q + 1;
    else                     dwell_q <= '0;
  end

  // R1
  desel_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> cmd_o == 4'd0);

  // R8
  cke_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cke_i) |-> !illegal_o);

  // R4
  quiet_never_flagged_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (cmd_o != 4'd0 && cmd_o != 4'd1));

  // R5
  refresh_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 2'd0 && state_o == 2'd1) |-> cmd_o == 4'd8);

  // R7
  modeset_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 2'd0 && state_o == 2'd2) |-> cmd_o == 4'd9);

  // R5
  refresh_dwell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 2'd1 && state_o != 2'd1) |-> (state_o == 2'd0 && dwell_q == T_RFC));

  // R7
  modeset_dwell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 2'd2 && state_o != 2'd2) |-> (state_o == 2'd0 && dwell_q == T_MRD));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.T_RFC(T_RFC), .T_MRD(T_MRD)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cke_i    (cke_i),
  .cs_ni    (cs_ni),
  .cmd_o    (cmd_o),
  .state_o  (state_o),
  .illegal_o(illegal_o)
);

// File: tb/sdram_cmd_monitor_test.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_test;
  localparam int T_RFC = 10;
  localparam int T_MRD = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic a10_i = 1'b0, banks_idle_i = 1'b1;
  logic [3:0] cmd_o;
  logic [1:0] state_o;
  logic illegal_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sdram_cmd_monitor #(.T_RFC(T_RFC), .T_MRD(T_MRD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni),
    .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .a10_i(a10_i),
    .banks_idle_i(banks_idle_i), .cmd_o(cmd_o), .state_o(state_o),
    .illegal_o(illegal_o)
  );

  // behavioural reference
  int m_cmd = 0, m_state = 0, m_ill = 0, m_cycles = 0, m_cke_prev = 0;

  function automatic int ref_decode(logic cs, logic r, logic c, logic w, logic a);
    if (cs) return 0;
    if (r && c) return w ? 1 : 2;
    if (r && !c) return w ? 3 : 4;
    if (!r && c) return w ? 5 : (a ? 7 : 6);
    return w ? 8 : 9;
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cmd = 0; m_state = 0; m_ill = 0; m_cycles = 0; m_cke_prev = 0;
    end else begin
      int old_state, limit;
      bit chk;
      chk = cke_i && (m_cke_prev != 0);
      m_cke_prev = cke_i;
      m_cmd = ref_decode(cs_ni, ras_ni, cas_ni, we_ni, a10_i);
      old_state = m_state;
      m_ill = 0;
      if (old_state == 0) begin
        if (chk && (m_cmd == 8 || m_cmd == 9)) begin
          if (!banks_idle_i) m_ill = 1;
          else begin
            m_state = (m_cmd == 8) ? 1 : 2;
            m_cycles = 1;
          end
        end
      end else begin
        if (chk && m_cmd > 1) m_ill = 1;
        limit = (old_state == 1) ? T_RFC : T_MRD;
        if (m_cycles == limit) m_state = 0;
        else m_cycles++;
      end
    end
  end

  task automatic compare(string req);
    checks++;
    if (cmd_o !== 4'(m_cmd) || state_o !== 2'(m_state) || illegal_o !== (m_ill != 0)) begin
      errors++;
      $display("FAIL %s: cmd=%0d state=%0d illegal=%0b expected cmd=%0d state=%0d illegal=%0d",
               req, cmd_o, state_o, illegal_o, m_cmd, m_state, m_ill);
    end
  endtask

  // pins = {cs, ras, cas, we}
  task automatic issue(logic [3:0] pins, logic a10, string req);
    {cs_ni, ras_ni, cas_ni, we_ni} = pins;
    a10_i = a10;
    @(negedge clk);
    compare(req);
  endtask

  task automatic idle_cycles(int n, string req);
    for (int i = 0; i < n; i++) issue(4'b0111, 1'b0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3 reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (cmd_o !== 4'd0 || state_o !== 2'd0 || illegal_o !== 1'b0) begin
        errors++;
        $display("FAIL R3: cmd=%0d state=%0d illegal=%0b expected 0 0 0", cmd_o, state_o, illegal_o);
      end
    end
    rst_ni = 1'b1;
    idle_cycles(2, "R11");

    // R1 chip select high masks other pins
    for (int p = 0; p < 16; p++) issue({1'b1, 3'(p)}, p[3], "R1");
    // R2 / R11 decode of every non-state command from idle
    issue(4'b0111, 1'b0, "R2");
    issue(4'b0110, 1'b0, "R2");
    issue(4'b0101, 1'b0, "R2");
    issue(4'b0100, 1'b0, "R2");
    issue(4'b0011, 1'b1, "R11");
    issue(4'b0010, 1'b0, "R2");
    issue(4'b0010, 1'b1, "R2");

    // R4 / R5 refresh entry, illegal commands, timed exit
    issue(4'b0001, 1'b0, "R5");
    issue(4'b1000, 1'b0, "R4");
    issue(4'b0110, 1'b0, "R4");
    issue(4'b0101, 1'b0, "R4");
    issue(4'b0100, 1'b0, "R4");
    issue(4'b0011, 1'b0, "R4");
    issue(4'b0010, 1'b1, "R4");
    issue(4'b0001, 1'b0, "R4");
    issue(4'b0000, 1'b0, "R4");
    idle_cycles(T_RFC + 2, "R5");
    // R10 back to back offence then quiet
    issue(4'b0001, 1'b0, "R10");
    issue(4'b0011, 1'b0, "R10");
    issue(4'b0011, 1'b0, "R10");
    issue(4'b0111, 1'b0, "R10");
    idle_cycles(T_RFC, "R5");

    // R6 / R7 mode register write
    issue(4'b0000, 1'b0, "R7");
    issue(4'b0101, 1'b0, "R6");
    issue(4'b0000, 1'b0, "R6");
    issue(4'b1111, 1'b0, "R6");
    idle_cycles(T_MRD + 2, "R7");
    issue(4'b0000, 1'b0, "R7");
    idle_cycles(T_MRD + 1, "R7");

    // R9 banks not idle
    banks_idle_i = 1'b0;
    issue(4'b0001, 1'b0, "R9");
    issue(4'b0000, 1'b0, "R9");
    issue(4'b0011, 1'b0, "R9");
    banks_idle_i = 1'b1;
    idle_cycles(1, "R9");

    // R8 clock enable gating
    cke_i = 1'b0;
    issue(4'b0001, 1'b0, "R8");
    cke_i = 1'b1;
    issue(4'b0001, 1'b0, "R8");
    issue(4'b0001, 1'b0, "R8");
    cke_i = 1'b0;
    issue(4'b0011, 1'b0, "R8");
    issue(4'b0000, 1'b0, "R8");
    cke_i = 1'b1;
    issue(4'b0011, 1'b0, "R8");
    issue(4'b0011, 1'b0, "R8");
    idle_cycles(T_RFC + 2, "R8");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule